// File: doc/BRIEF.md
# Serial Audio Transmitter with Counter-Derived Frame Sync

This block sends 16-bit left-justified stereo audio over a three-wire serial link made of a bit clock, a data line and a frame-sync line. Its data path works like a byte-wide shift master. It shifts each byte out MSB first, one bit per bit-clock period. The frame-sync line is not tied to the data path. An up-counter, advanced on every rising bit-clock transition, compares its value against a threshold and toggles the line at that threshold and again when the counter wraps. The result is a 50% duty-cycle frame strobe whose edges always fall on rising bit-clock transitions.

A counter-derived frame strobe runs one bit period ahead of the data, so the block realigns the data itself. It keeps one byte of look-ahead and sends each byte shifted left by one place, with the MSB of the following byte placed in its lowest bit. The upstream source offers bytes through a valid/ready handshake. The system clock runs much faster than the bit clock, and a strobe input sets the bit-clock pace: every strobe toggles the bit-clock output once.

Top module: `i2s_shift_tx`

## Requirements
- R1: The bclk output toggles on each clock cycle where bclk_en is high, and holds its level on every cycle where bclk_en is low.
- R2: Count r as the number of rising bclk transitions since reset. After the r-th one, fs is high exactly when (r mod (MOD+1)) >= CMP. The defaults CMP=16 and MOD=31 give 32 bit periods per frame, with fs low for the first 16 (left channel) and high for the last 16 (right channel).
- R3: fs changes level only together with a rising bclk transition.
- R4: txd changes level only together with a falling bclk transition.
- R5: For accepted bytes b0, b1, b2, ..., the block sends the bytes {bk[6:0], bk+1[7]} in order. Each is sent MSB first, one bit per bclk period, with no gaps while the source keeps bytes available. The first such bit is on txd right after the falling bclk transition at which b1 is accepted.
- R6: Until a second byte has been accepted since reset, txd stays low.
- R7: If no merged byte is ready when a byte's last bit period ends, txd goes low and stays low, while bclk and fs keep running.
- R8: With the look-ahead buffer empty, in_ready is high. With a byte held, in_ready is high only on a cycle that makes a falling bclk transition and ends the last bit period of the byte being sent (or finds the shifter idle).
- R9: While rst is high, on the following cycle bclk, fs and txd are low, the frame counter is zero, and the look-ahead buffer is empty (in_ready high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_en | input | 1 | Strobe; each pulse toggles bclk once |
| in_valid | input | 1 | Upstream byte available |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Block accepts in_data this cycle |
| bclk | output | 1 | Serial bit clock |
| txd | output | 1 | Serial data, MSB first |
| fs | output | 1 | Frame sync, low for the left channel |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a compare value of 16 and a modulo of 31. This gives a 32-period frame, so several full frames and both fs edges show up within a few hundred system cycles. The bclk strobe is pulsed every other system cycle. A seven-byte stream then shows the one-bit realignment across byte boundaries whose MSBs are 0 and 1, the idle tail after the source runs dry, and the exact fs phase counted from reset. A second run after a mid-stream reset holds back the second byte, which exposes the look-ahead wait.

// File: rtl/i2s_shift_tx.sv
module i2s_shift_tx #(
  parameter int DW  = 8,
  parameter int CMP = 16,
  parameter int MOD = 31,
  localparam int CW = $clog2(MOD + 1),
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          bclk,
  output logic          txd,
  output logic          fs
);

  localparam logic [CW-1:0] CMP_C = CW'(CMP);
  localparam logic [CW-1:0] MOD_C = CW'(MOD);
  localparam logic [BW-1:0] ONE   = BW'(1);
  localparam logic [BW-1:0] FULL  = BW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] hold, shreg;
  logic          hold_vld;
  logic [BW-1:0] left;

  wire rise     = bclk_en & ~bclk;
  wire fall     = bclk_en & bclk;
  wire slot_end = fall && (left <= ONE);
  wire take     = in_valid && in_ready;
  wire load     = take && hold_vld;

  wire [DW-1:0] merged = {hold[DW-2:0], in_data[DW-1]};
  wire [CW-1:0] cnt_nx = (cnt == MOD_C) ? '0 : cnt + 1'b1;

  assign in_ready = !hold_vld || slot_end;
  assign txd      = shreg[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk     <= 1'b0;
      fs       <= 1'b0;
      cnt      <= '0;
      hold     <= '0;
      hold_vld <= 1'b0;
      shreg    <= '0;
      left     <= '0;
    end else begin
      if (bclk_en) bclk <= ~bclk;
      if (rise) begin
        cnt <= cnt_nx;
        fs  <= (cnt_nx >= CMP_C);
      end
      if (take) begin
        hold     <= in_data;
        hold_vld <= 1'b1;
      end
      if (fall) begin
        if (left > ONE) begin
          shreg <= shreg << 1;
          left  <= left - ONE;
        end else if (load) begin
          shreg <= merged;
          left  <= FULL;
        end else begin
          shreg <= '0;
          left  <= '0;
        end
      end
    end
  end

endmodule

module i2s_shift_tx_chk (
  input logic clk,
  input logic rst,
  input logic bclk_en,
  input logic bclk,
  input logic fs,
  input logic txd,
  input logic in_ready,
  input logic hold_vld
);

  assert_bclk_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    bclk_en |=> (bclk != $past(bclk)));

  assert_bclk_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !bclk_en |=> $stable(bclk));

  assert_fs_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$stable(fs)) |-> $rose(bclk));

  assert_txd_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$stable(txd)) |-> $fell(bclk));

  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (hold_vld && in_ready) |-> (bclk && bclk_en));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!bclk && !fs && !txd && in_ready));

endmodule

bind i2s_shift_tx i2s_shift_tx_chk u_chk (
  .clk(clk), .rst(rst), .bclk_en(bclk_en), .bclk(bclk), .fs(fs),
  .txd(txd), .in_ready(in_ready), .hold_vld(hold_vld)
);

// File: tb/test_i2s_shift_tx.sv
module test_i2s_shift_tx;

  localparam int CMP = 16;
  localparam int MOD = 31;
  localparam int NV  = 7;
  localparam int MAXC = 256;

  typedef struct packed { logic [7:0] stim; logic [7:0] exp; } vec_t;
  // exp of row k = {stim_k[6:0], stim_k+1[7]}; last row has no successor
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 8'h4A}, '{8'h3C, 8'h79}, '{8'hFF, 8'hFE}, '{8'h00, 8'h01},
    '{8'h81, 8'h02}, '{8'h7E, 8'hFD}, '{8'hC3, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, bclk, txd, fs;

  always #2 clk = ~clk;

  i2s_shift_tx i_i2s_shift_tx (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .bclk(bclk), .txd(txd), .fs(fs)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] src [8];
  int nsrc = 0, idx = 0, nacc = 0, nrise = 0, ncap = 0;
  logic cap [MAXC];
  logic prev_b = 1'b0, fire = 1'b0, en_on = 1'b0, cap_on = 1'b0;
  logic rdy_bad = 1'b0, txd_early = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic tick();
    logic rose, fexp;
    @(negedge clk);
    rose = bclk && !prev_b;
    prev_b = bclk;
    if (!rst && rose) begin
      nrise++;
      fexp = ((nrise % (MOD + 1)) >= CMP);
      check(fs == fexp, "R2 fs phase", fs, fexp);
      if (cap_on && ncap < MAXC) begin cap[ncap] = txd; ncap++; end
    end
    if (!rst && nacc < 2 && txd) txd_early = 1'b1;
    if (fire) begin
      idx++; nacc++;
      if (nacc == 2) cap_on = 1'b1;
    end
    bclk_en = en_on ? ~bclk_en : 1'b0;
    in_valid = !rst && idx < nsrc;
    in_data = (idx < nsrc) ? src[idx] : 8'h00;
    #1;
    if (nacc >= 1 && in_ready && !(bclk_en && bclk)) rdy_bad = 1'b1;
    fire = in_valid && in_ready;
  endtask

  task automatic do_reset();
    rst = 1'b1; en_on = 1'b0;
    nsrc = 0; idx = 0; nacc = 0; nrise = 0; ncap = 0;
    cap_on = 1'b0; fire = 1'b0; prev_b = 1'b0; txd_early = 1'b0;
    repeat (3) tick();
    // R9: reset state visible at ports
    check(!bclk && !fs && !txd, "R9 outputs low in reset", {bclk, fs, txd}, 0);
    check(in_ready, "R9 look-ahead empty", in_ready, 1);
    @(posedge clk); #1 rst = 1'b0; en_on = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic b_hold, f_hold;
    logic zero;
    do_reset();
    for (int i = 0; i < NV; i++) src[i] = VEC[i].stim;
    nsrc = NV;
    repeat (300) tick();
    // R5: each merged byte MSB first
    for (int r = 0; r < NV - 1; r++) begin
      for (int b = 0; b < 8; b++) got[7-b] = cap[8*r+b];
      check(got == VEC[r].exp, "R5 merged byte", got, VEC[r].exp);
    end
    check(nacc == NV, "R8 all bytes accepted", nacc, NV);
    // R7: idle tail low
    zero = 1'b1;
    for (int b = 8*(NV-1); b < 8*(NV-1) + 16; b++) if (cap[b]) zero = 1'b0;
    check(zero, "R7 idle txd low", zero, 1);
    check(!rdy_bad, "R8 ready only at byte end", rdy_bad, 0);
    // R1: bclk frozen without strobe
    en_on = 1'b0;
    repeat (2) tick();
    b_hold = bclk; f_hold = fs;
    repeat (10) tick();
    check(bclk == b_hold && fs == f_hold, "R1 bclk holds", {bclk, fs}, {b_hold, f_hold});
    en_on = 1'b1;
    repeat (6) tick();

    // mid-stream reset, then one byte only
    do_reset();
    src[0] = 8'hFF; src[1] = 8'h80; nsrc = 1;
    repeat (120) tick();
    check(nacc == 1, "R6 one byte held", nacc, 1);
    check(!txd_early, "R6 no data before second byte", txd_early, 0);
    nsrc = 2;
    repeat (60) tick();
    for (int b = 0; b < 8; b++) got[7-b] = cap[b];
    check(got == 8'hFF, "R5 first merged after wait", got, 8'hFF);
    zero = 1'b1;
    for (int b = 8; b < 14; b++) if (cap[b]) zero = 1'b0;
    check(zero, "R7 idle after single merge", zero, 1);
    check(!rdy_bad, "R8 ready gating second run", rdy_bad, 0);
    finish_run();
  end

endmodule